// File: doc/BRIEF.md
# Write-Once Synchronization Cell Bank

This block holds a bank of data cells that can each be written exactly once. Each cell keeps a presence state alongside its data. Several requester ports share the bank. Each port has a valid/ready request channel carrying an operation, a cell address, store data and a wait limit. Each port also has a response channel carrying a status and data.

A load to a cell that already holds data returns at once. A load to an empty cell parks the port. The port then waits until some port stores to that cell, or until the port's own countdown runs out. The one store that fills a cell answers every parked port in the same cycle with the stored value. A later store to a filled cell is trapped as an error, and the stored data stays as it was. A reinitialize operation returns a filled or errored cell to empty so that it can be used again.

A port has at most one request in flight. A port that is waiting accepts nothing else until its load is answered.

Top module: `sacell_bank`

## Requirements
- R1: After reset every cell is empty, no response is valid, and an idle port shows ready.
- R2: A load accepted on a cell in the full state answers one cycle later with status ok (code 0) and the stored data. Operation codes are load 0, store 1, reinitialize 2, and 3 unused.
- R3: A load accepted on an empty cell produces no response until a store to that cell or a timeout, and the port holds ready low while it waits.
- R4: A store accepted on an empty cell answers the storer with ok and its own data one cycle later. In that same cycle, every port parked on the cell gets ok with the stored data.
- R5: A store accepted on a cell that is full or already in error answers error (code 2) with the data the cell already held. The cell enters the error state, its data is not changed, and later loads of it answer error with that data.
- R6: A load that parks with wait limit k answers timeout (code 1) with data 0 exactly k+1 cycles after it was accepted. The port's waiter entry is then gone, so a later store to the cell does not answer that port.
- R7: When a store to the cell is accepted in the same cycle that a parked port's countdown expires, the port gets ok with the stored data and no timeout.
- R8: Reinitialize answers ok with data 0 one cycle later. It returns a full or error cell to empty. On an empty cell it changes nothing, and ports parked there stay parked.
- R9: When several ports present a store or reinitialize to the same cell in one cycle, only the lowest-numbered port is ready. Loads to that cell are held off with ready low in that cycle.
- R10: The unused operation code 3 answers error with data 0 one cycle later and leaves the cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request valid, one bit per port |
| req_ready | output | NPORT | Request accepted when valid and ready are both high |
| req_op | input | 2*NPORT | Operation code per port |
| req_addr | input | ADDR_W*NPORT | Cell address per port |
| req_data | input | DATA_W*NPORT | Store data per port |
| req_tmo | input | TMO_W*NPORT | Wait limit per port, used when a load parks |
| rsp_valid | output | NPORT | One-cycle response strobe per port |
| rsp_status | output | 2*NPORT | Response status per port: ok 0, timeout 1, error 2 |
| rsp_data | output | DATA_W*NPORT | Response data per port |

## Verification
Every response is registered. A fast load, a store answer, a reinitialize answer, an unused-code answer and a store's wake-up of parked ports all appear in the cycle after the accepting edge. A timeout appears k+1 cycles after the accepting edge. The bench drives requests on the falling edge and samples on the following falling edge, which is the first point where the registered response can be seen. For waits, it counts falling edges from the acceptance and confirms silence on each one before the expected response cycle. The race case times the store so that it is accepted on exactly the edge where the countdown reaches zero.

// File: rtl/sacell_pkg.sv
package sacell_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_REINIT = 2'd2,
        OP_RSVD   = 2'd3
    } sc_op_e;

    typedef enum logic [1:0] {
        RS_OK      = 2'd0,
        RS_TIMEOUT = 2'd1,
        RS_ERROR   = 2'd2
    } sc_status_e;

    typedef enum logic [1:0] {
        CS_EMPTY      = 2'd0,
        CS_EMPTY_WAIT = 2'd1,
        CS_FULL       = 2'd2,
        CS_ERROR      = 2'd3
    } cell_state_e;

    function automatic logic cell_is_empty(cell_state_e s);
        return (s == CS_EMPTY) || (s == CS_EMPTY_WAIT);
    endfunction

endpackage

// File: rtl/sacell_cell.sv
module sacell_cell
    import sacell_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              reinit_en,
    input  logic [NPORT-1:0]  park,
    input  logic [NPORT-1:0]  drop,
    output cell_state_e       state_o,
    output logic [DATA_W-1:0] data_o
);

    cell_state_e       state_q;
    logic [DATA_W-1:0] data_q;
    logic [NPORT-1:0]  waiters_q;
    logic [NPORT-1:0]  waiters_n;

    assign waiters_n = (waiters_q & ~drop) | park;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CS_EMPTY;
            data_q    <= '0;
            waiters_q <= '0;
        end else if (wr_en) begin
            if (cell_is_empty(state_q)) begin
                state_q <= CS_FULL;
                data_q  <= wr_data;
            end else begin
                state_q <= CS_ERROR;
            end
            waiters_q <= '0;
        end else if (reinit_en && !cell_is_empty(state_q)) begin
            state_q   <= CS_EMPTY;
            waiters_q <= '0;
        end else if (cell_is_empty(state_q)) begin
            waiters_q <= waiters_n;
            state_q   <= (waiters_n != '0) ? CS_EMPTY_WAIT : CS_EMPTY;
        end
    end

    assign state_o = state_q;
    assign data_o  = data_q;

endmodule

// File: rtl/sacell_waiter.sv
module sacell_waiter #(
    parameter int ADDR_W = 3,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              park,
    input  logic [ADDR_W-1:0] park_addr,
    input  logic [TMO_W-1:0]  park_tmo,
    input  logic              release_i,
    output logic              waiting_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              expire_o
);

    logic              waiting_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TMO_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting_q <= 1'b0;
            addr_q    <= '0;
            cnt_q     <= '0;
        end else if (park) begin
            waiting_q <= 1'b1;
            addr_q    <= park_addr;
            cnt_q     <= park_tmo;
        end else if (waiting_q) begin
            if (release_i || cnt_q == '0) begin
                waiting_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign waiting_o = waiting_q;
    assign addr_o    = addr_q;
    assign expire_o  = waiting_q && (cnt_q == '0) && !release_i;

endmodule

// File: rtl/sacell_bank.sv
module sacell_bank
    import sacell_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int NCELL  = 8,
    parameter int DATA_W = 32,
    parameter int TMO_W  = 8,
    localparam int ADDR_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        req_valid,
    output logic [NPORT-1:0]        req_ready,
    input  logic [2*NPORT-1:0]      req_op,
    input  logic [ADDR_W*NPORT-1:0] req_addr,
    input  logic [DATA_W*NPORT-1:0] req_data,
    input  logic [TMO_W*NPORT-1:0]  req_tmo,
    output logic [NPORT-1:0]        rsp_valid,
    output logic [2*NPORT-1:0]      rsp_status,
    output logic [DATA_W*NPORT-1:0] rsp_data
);

    typedef struct packed {
        logic              valid;
        sc_status_e        status;
        logic [DATA_W-1:0] data;
    } rsp_t;

    sc_op_e            op      [NPORT];
    logic [ADDR_W-1:0] addr    [NPORT];
    logic [DATA_W-1:0] wdat    [NPORT];
    logic [TMO_W-1:0]  tmo     [NPORT];

    logic [NPORT-1:0]  wait_q, expire, release_w, park;
    logic [NPORT-1:0]  mut_gnt, ld_gnt, bad_gnt, mut_req;
    logic [ADDR_W-1:0] wait_addr [NPORT];

    cell_state_e       cell_st   [NCELL];
    logic [DATA_W-1:0] cell_dat  [NCELL];
    logic [NCELL-1:0]  cell_wr, cell_reinit, cell_busy;
    logic [DATA_W-1:0] cell_wdata [NCELL];
    logic [NPORT-1:0]  cell_park [NCELL];
    logic [NPORT-1:0]  cell_drop [NCELL];

    logic [2*NCELL-1:0]      cell_st_flat;
    logic [DATA_W*NCELL-1:0] cell_dat_flat;

    rsp_t rsp_q [NPORT];
    rsp_t rsp_n [NPORT];

    // Unpack per-port request fields
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            op[p]   = sc_op_e'(req_op[2*p +: 2]);
            addr[p] = req_addr[ADDR_W*p +: ADDR_W];
            wdat[p] = req_data[DATA_W*p +: DATA_W];
            tmo[p]  = req_tmo[TMO_W*p +: TMO_W];
        end
    end

    // Arbitration: lowest port wins a mutating op on a given cell
    logic [NPORT-1:0] lower_conflict;
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            mut_req[p] = req_valid[p] && !wait_q[p] &&
                         (op[p] == OP_STORE || op[p] == OP_REINIT);
        end
        for (int p = 0; p < NPORT; p++) begin
            lower_conflict[p] = 1'b0;
            for (int q = 0; q < p; q++) begin
                if (mut_req[q] && addr[q] == addr[p]) lower_conflict[p] = 1'b1;
            end
            mut_gnt[p] = mut_req[p] && !lower_conflict[p];
        end
        for (int c = 0; c < NCELL; c++) begin
            cell_wr[c]     = 1'b0;
            cell_reinit[c] = 1'b0;
            cell_wdata[c]  = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (mut_gnt[p] && addr[p] == ADDR_W'(c)) begin
                    if (op[p] == OP_STORE) begin
                        cell_wr[c]    = 1'b1;
                        cell_wdata[c] = wdat[p];
                    end else begin
                        cell_reinit[c] = 1'b1;
                    end
                end
            end
            cell_busy[c] = cell_wr[c] || cell_reinit[c];
        end
    end

    // Loads, parking, wake-up and ready
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            ld_gnt[p]  = req_valid[p] && !wait_q[p] && op[p] == OP_LOAD &&
                         !cell_busy[addr[p]];
            bad_gnt[p] = req_valid[p] && !wait_q[p] && op[p] == OP_RSVD;
            park[p]    = ld_gnt[p] && cell_is_empty(cell_st[addr[p]]);
            release_w[p] = wait_q[p] && cell_wr[wait_addr[p]] &&
                           cell_is_empty(cell_st[wait_addr[p]]);
            if (wait_q[p])               req_ready[p] = 1'b0;
            else if (op[p] == OP_LOAD)   req_ready[p] = !cell_busy[addr[p]];
            else if (op[p] == OP_RSVD)   req_ready[p] = 1'b1;
            else                         req_ready[p] = !lower_conflict[p];
        end
        for (int c = 0; c < NCELL; c++) begin
            for (int p = 0; p < NPORT; p++) begin
                cell_park[c][p] = park[p] && addr[p] == ADDR_W'(c);
                cell_drop[c][p] = expire[p] && wait_addr[p] == ADDR_W'(c);
            end
        end
    end

    // Response selection
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            rsp_n[p] = '{valid: 1'b0, status: RS_OK, data: '0};
            if (release_w[p]) begin
                rsp_n[p] = '{valid: 1'b1, status: RS_OK, data: cell_wdata[wait_addr[p]]};
            end else if (expire[p]) begin
                rsp_n[p] = '{valid: 1'b1, status: RS_TIMEOUT, data: '0};
            end else if (ld_gnt[p] && !park[p]) begin
                rsp_n[p].valid  = 1'b1;
                rsp_n[p].status = (cell_st[addr[p]] == CS_FULL) ? RS_OK : RS_ERROR;
                rsp_n[p].data   = cell_dat[addr[p]];
            end else if (mut_gnt[p]) begin
                rsp_n[p].valid = 1'b1;
                if (op[p] == OP_REINIT) begin
                    rsp_n[p].status = RS_OK;
                end else if (cell_is_empty(cell_st[addr[p]])) begin
                    rsp_n[p].status = RS_OK;
                    rsp_n[p].data   = wdat[p];
                end else begin
                    rsp_n[p].status = RS_ERROR;
                    rsp_n[p].data   = cell_dat[addr[p]];
                end
            end else if (bad_gnt[p]) begin
                rsp_n[p] = '{valid: 1'b1, status: RS_ERROR, data: '0};
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (rst) rsp_q[p] <= '{valid: 1'b0, status: RS_OK, data: '0};
            else     rsp_q[p] <= rsp_n[p];
        end
    end

    genvar gp, gc;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_port
            sacell_waiter #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_wait (
                .clk       (clk),
                .rst       (rst),
                .park      (park[gp]),
                .park_addr (addr[gp]),
                .park_tmo  (tmo[gp]),
                .release_i (release_w[gp]),
                .waiting_o (wait_q[gp]),
                .addr_o    (wait_addr[gp]),
                .expire_o  (expire[gp])
            );
            assign rsp_valid[gp]                   = rsp_q[gp].valid;
            assign rsp_status[2*gp +: 2]           = rsp_q[gp].status;
            assign rsp_data[DATA_W*gp +: DATA_W]   = rsp_q[gp].data;
        end
        for (gc = 0; gc < NCELL; gc++) begin : g_cell
            sacell_cell #(.NPORT(NPORT), .DATA_W(DATA_W)) u_cell (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (cell_wr[gc]),
                .wr_data   (cell_wdata[gc]),
                .reinit_en (cell_reinit[gc]),
                .park      (cell_park[gc]),
                .drop      (cell_drop[gc]),
                .state_o   (cell_st[gc]),
                .data_o    (cell_dat[gc])
            );
            assign cell_st_flat[2*gc +: 2]            = cell_st[gc];
            assign cell_dat_flat[DATA_W*gc +: DATA_W] = cell_dat[gc];
        end
    endgenerate

endmodule

// File: rtl/sacell_bank_chk.sv
module sacell_bank_chk #(
    parameter int NPORT  = 4,
    parameter int NCELL  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NPORT-1:0]        req_valid,
    input logic [NPORT-1:0]        req_ready,
    input logic [2*NPORT-1:0]      req_op,
    input logic [ADDR_W*NPORT-1:0] req_addr,
    input logic [NPORT-1:0]        rsp_valid,
    input logic [2*NPORT-1:0]      rsp_status,
    input logic [2*NCELL-1:0]      cell_st_flat,
    input logic [DATA_W*NCELL-1:0] cell_dat_flat,
    input logic [NPORT-1:0]        wait_q
);

    logic [1:0] st_at_req [NPORT];
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            st_at_req[p] = cell_st_flat[2*req_addr[ADDR_W*p +: ADDR_W] +: 2];
        end
    end

    genvar gp, gc;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_pchk
            // R3: a parked port accepts nothing
            assert_park_blocks_R3: assert property (@(posedge clk) disable iff (rst)
                wait_q[gp] |-> !req_ready[gp]);
            // R2: load on a full cell answers ok next cycle
            assert_fast_load_R2: assert property (@(posedge clk) disable iff (rst)
                (req_valid[gp] && req_ready[gp] && req_op[2*gp +: 2] == 2'd0 &&
                 st_at_req[gp] == 2'd2)
                |=> (rsp_valid[gp] && rsp_status[2*gp +: 2] == 2'd0));
            // R5: store on full or error cell answers error next cycle
            assert_second_store_R5: assert property (@(posedge clk) disable iff (rst)
                (req_valid[gp] && req_ready[gp] && req_op[2*gp +: 2] == 2'd1 &&
                 st_at_req[gp][1])
                |=> (rsp_valid[gp] && rsp_status[2*gp +: 2] == 2'd2));
            // R6: a timeout only follows a cycle spent parked
            assert_timeout_source_R6: assert property (@(posedge clk) disable iff (rst)
                (rsp_valid[gp] && rsp_status[2*gp +: 2] == 2'd1) |-> $past(wait_q[gp]));
            // R10: status code 3 never appears
            assert_status_code_R10: assert property (@(posedge clk) disable iff (rst)
                rsp_valid[gp] |-> (rsp_status[2*gp +: 2] != 2'd3));
        end
        for (gc = 0; gc < NCELL; gc++) begin : g_cchk
            // R5: data of a filled or errored cell never changes
            assert_write_once_R5: assert property (@(posedge clk) disable iff (rst)
                cell_st_flat[2*gc+1] |=> $stable(cell_dat_flat[DATA_W*gc +: DATA_W]));
        end
    endgenerate

endmodule

bind sacell_bank sacell_bank_chk #(
    .NPORT(NPORT), .NCELL(NCELL), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .cell_st_flat  (cell_st_flat),
    .cell_dat_flat (cell_dat_flat),
    .wait_q        (wait_q)
);

// File: tb/tb_sacell_bank.sv
module tb_sacell_bank;

    localparam int NP = 4;
    localparam int NC = 8;
    localparam int DW = 32;
    localparam int TW = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]    req_valid = '0;
    logic [NP-1:0]    req_ready;
    logic [2*NP-1:0]  req_op = '0;
    logic [AW*NP-1:0] req_addr = '0;
    logic [DW*NP-1:0] req_data = '0;
    logic [TW*NP-1:0] req_tmo = '0;
    logic [NP-1:0]    rsp_valid;
    logic [2*NP-1:0]  rsp_status;
    logic [DW*NP-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sacell_bank #(.NPORT(NP), .NCELL(NC), .DATA_W(DW), .TMO_W(TW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_tmo(req_tmo),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_req(input int p, input logic [1:0] op, input int a, input logic [DW-1:0] d, input int t);
        req_valid[p] = 1'b1;
        req_op[2*p +: 2] = op;
        req_addr[AW*p +: AW] = AW'(a);
        req_data[DW*p +: DW] = d;
        req_tmo[TW*p +: TW] = TW'(t);
    endtask

    task automatic clr_req(input int p);
        req_valid[p] = 1'b0;
        req_op[2*p +: 2] = 2'd0;
    endtask

    // expect a response (or none) on port p at the current sample point
    task automatic chk_rsp(input int p, input bit v, input logic [1:0] st, input logic [DW-1:0] d, input string tag);
        check(rsp_valid[p] == v, {tag, " rsp_valid"}, 64'(rsp_valid[p]), 64'(v));
        if (v) begin
            check(rsp_status[2*p +: 2] == st, {tag, " status"}, 64'(rsp_status[2*p +: 2]), 64'(st));
            check(rsp_data[DW*p +: DW] == d, {tag, " data"}, 64'(rsp_data[DW*p +: DW]), 64'(d));
        end
    endtask

    // single request on one port, accepted on next edge, answer sampled
    task automatic one_op(input int p, input logic [1:0] op, input int a, input logic [DW-1:0] d, input int t);
        set_req(p, op, a, d, t);
        #1;
        check(req_ready[p] == 1'b1, "ready before accept", 64'(req_ready[p]), 64'd1);
        tick();
        clr_req(p);
    endtask

    task automatic t_reset();
        check(rsp_valid == '0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        check(req_ready == '1, "R1 idle ready", 64'(req_ready), 64'hF);
    endtask

    task automatic t_store_and_fast_load();
        one_op(0, 2'd1, 1, 32'hA5, 0);
        chk_rsp(0, 1, 2'd0, 32'hA5, "R4 store to empty ok");
        one_op(2, 2'd0, 1, 0, 5);
        chk_rsp(2, 1, 2'd0, 32'hA5, "R2 fast load");
    endtask

    task automatic t_wait_release();
        set_req(0, 2'd0, 2, 0, 50);
        set_req(1, 2'd0, 2, 0, 50);
        tick();
        clr_req(0); clr_req(1);
        for (int i = 0; i < 4; i++) begin
            check(rsp_valid[1:0] == 2'b00, "R3 no early answer", 64'(rsp_valid), 64'd0);
            check(req_ready[1:0] == 2'b00, "R3 ready low while waiting", 64'(req_ready), 64'd0);
            tick();
        end
        one_op(3, 2'd1, 2, 32'h1234, 0);
        chk_rsp(0, 1, 2'd0, 32'h1234, "R4 waiter0 woken");
        chk_rsp(1, 1, 2'd0, 32'h1234, "R4 waiter1 woken");
        chk_rsp(3, 1, 2'd0, 32'h1234, "R4 storer ok");
    endtask

    task automatic t_double_store();
        one_op(1, 2'd1, 2, 32'h9999, 0);
        chk_rsp(1, 1, 2'd2, 32'h1234, "R5 second store error");
        one_op(0, 2'd0, 2, 0, 5);
        chk_rsp(0, 1, 2'd2, 32'h1234, "R5 load of error cell");
    endtask

    task automatic t_reinit_timeout();
        one_op(2, 2'd2, 2, 0, 0);
        chk_rsp(2, 1, 2'd0, 0, "R8 reinit ok");
        one_op(0, 2'd0, 2, 0, 3);
        for (int i = 0; i < 3; i++) begin
            chk_rsp(0, 0, 2'd0, 0, "R6 silent before limit");
            tick();
        end
        chk_rsp(0, 0, 2'd0, 0, "R6 silent at k");
        tick();
        chk_rsp(0, 1, 2'd1, 0, "R6 timeout at k+1");
        one_op(1, 2'd1, 2, 32'h4242, 0);
        chk_rsp(1, 1, 2'd0, 32'h4242, "R8 refill after reinit");
        chk_rsp(0, 0, 2'd0, 0, "R6 timed-out port not woken");
    endtask

    task automatic t_reinit_empty();
        one_op(0, 2'd0, 3, 0, 40);
        one_op(1, 2'd2, 3, 0, 0);
        chk_rsp(1, 1, 2'd0, 0, "R8 reinit on empty ok");
        chk_rsp(0, 0, 2'd0, 0, "R8 waiter still parked");
        check(req_ready[0] == 1'b0, "R8 waiter still busy", 64'(req_ready[0]), 64'd0);
        one_op(2, 2'd1, 3, 32'h77, 0);
        chk_rsp(0, 1, 2'd0, 32'h77, "R8 waiter kept across reinit");
    endtask

    task automatic t_race();
        one_op(0, 2'd0, 4, 0, 2);
        chk_rsp(0, 0, 2'd0, 0, "R7 silent N0");
        tick();
        chk_rsp(0, 0, 2'd0, 0, "R7 silent N1");
        tick();
        chk_rsp(0, 0, 2'd0, 0, "R7 silent N2");
        one_op(1, 2'd1, 4, 32'h55, 0);
        chk_rsp(0, 1, 2'd0, 32'h55, "R7 store beats timeout");
        tick();
        chk_rsp(0, 0, 2'd0, 0, "R7 no trailing timeout");
    endtask

    task automatic t_conflict();
        set_req(1, 2'd1, 5, 32'h111, 0);
        set_req(2, 2'd1, 5, 32'h222, 0);
        set_req(3, 2'd0, 5, 0, 9);
        #1;
        check(req_ready[1] == 1'b1, "R9 lowest wins", 64'(req_ready[1]), 64'd1);
        check(req_ready[2] == 1'b0, "R9 higher store held", 64'(req_ready[2]), 64'd0);
        check(req_ready[3] == 1'b0, "R9 load held", 64'(req_ready[3]), 64'd0);
        tick();
        clr_req(1); clr_req(2); clr_req(3);
        chk_rsp(1, 1, 2'd0, 32'h111, "R9 winner ok");
        chk_rsp(2, 0, 2'd0, 0, "R9 loser silent");
        chk_rsp(3, 0, 2'd0, 0, "R9 load silent");
        one_op(3, 2'd0, 5, 0, 9);
        chk_rsp(3, 1, 2'd0, 32'h111, "R9 cell holds winner data");
    endtask

    task automatic t_badop();
        one_op(0, 2'd3, 6, 32'hDEAD, 0);
        chk_rsp(0, 1, 2'd2, 0, "R10 unused code error");
        one_op(1, 2'd1, 6, 32'hBEEF, 0);
        chk_rsp(1, 1, 2'd0, 32'hBEEF, "R10 cell left empty");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_store_and_fast_load();
        t_wait_release();
        t_double_store();
        t_reinit_timeout();
        t_reinit_empty();
        t_race();
        t_conflict();
        t_badop();
        tick();
        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule